// File: doc/BRIEF.md
# Precision Time Counter

This block keeps a running time of day for a precision-time-protocol clock: a 32-bit seconds count and a nanoseconds count that always stays below one billion. The rate is set by a fractional phase accumulator. On every enabled clock a 32-bit addend is added to the accumulator. Each carry out of the accumulator advances the nanoseconds by a fixed step. The nanoseconds roll into the seconds at one billion. Software trims the rate by loading a new addend, so a servo can steer the clock without touching the count itself.

Software reaches the block through a small write port of eight-word registers. The control word sits at address 0. The addend holding register is at address 1. The seconds and nanoseconds update registers are at addresses 3 and 4, and the target seconds and nanoseconds are at addresses 5 and 6. Three self-clearing request bits in the control word do three jobs: they apply a new addend, they load the time from the update registers, and they add a signed offset to the running time. A one-shot target comparison raises a status flag. That flag drives the interrupt line unless a mask bit is set, and a read strobe clears it.

The control word is laid out as follows. Bit 0 is the count enable and bit 1 is the interrupt mask; both are stored on every control write. Bits 2 to 5 are write-one-to-request bits: time load, offset, addend apply and target arm. Writing a 0 to one of them has no effect.

Top module: `ptp_time_counter`

## Requirements
- R1: On every cycle with the count enable (control bit 0) set, the active addend is added to a 32-bit accumulator that reset clears. The nanoseconds grow by the step only when that addition carries out of bit 31. The step is 10 ns when the clock is above 200 MHz, 20 ns above 100 MHz and 50 ns otherwise, so it is 20 ns at the default 125 MHz.
- R2: When an advance brings the nanoseconds to 1,000,000,000 or more, they lose 1,000,000,000 and the seconds grow by one. The seconds wrap modulo 2^32.
- R3: A value written to address 1 takes effect only after control bit 4 is written as 1. The addend-busy output then reads 1 for exactly one cycle, and the new addend is used from the following cycle on. Out of reset the active addend is round(1e9 × 2^32 / (f_clk × step)), which is 1717986918 at the defaults.
- R4: Writing control bit 2 loads the seconds (address 3) and the nanoseconds (address 4) into the running time together, at the clock edge after the control write. Init-busy reads 1 in the cycle between the two edges.
- R5: A time-load or offset request is ignored while a time load or an offset is already pending. If one write requests both, only the load takes place.
- R6: Writing control bit 3 applies an offset. Bit 31 of address 4 is the sign (1 = subtract) and bits 30:0 are a nanosecond magnitude below 1e9; address 3 holds the seconds magnitude. An addition carries into the seconds above 999,999,999 ns. A subtraction borrows one second, adding 1,000,000,000 ns, when the nanoseconds would go negative. Adjust-busy reads 1 for one cycle.
- R7: While control bit 0 is clear, the time and the accumulator stay still, apart from loads and offsets.
- R8: While the target is armed (control bit 5 write, readable on targetArmed), the block compares the running time with the target pair {address 5, address 6}. Once the time is at or past the target, the target flag sets at the next edge and the armed bit clears, so the flag fires only once.
- R9: The interrupt equals the target flag while the mask (control bit 1) is clear and is 0 while the mask is set. A pulse on statusRead clears the flag, but a new hit in the same cycle wins.
- R10: After reset the time, the accumulator, every busy output, the armed bit, the flag and the interrupt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| statusRead | input | 1 | Read strobe of the status word; clears the target flag |
| timeSec | output | 32 | Current seconds |
| timeNs | output | 32 | Current nanoseconds, same cycle as timeSec |
| addendBusy | output | 1 | Addend apply pending |
| initBusy | output | 1 | Time load pending |
| adjustBusy | output | 1 | Offset pending |
| targetArmed | output | 1 | Target comparison armed |
| targetFlag | output | 1 | Target reached status |
| irq | output | 1 | Interrupt line |

## Verification
A register write lands at the edge where wrEn is sampled, so a busy bit is visible one cycle later and the loaded or adjusted time one cycle after that. The bench samples 1 ns after each edge, right at those points. Counting runs are framed by two control writes M edges apart, which gives exactly M enabled cycles. The bench predicts the carries as floor((acc + M × addend) / 2^32) and keeps its own accumulator figure in plain arithmetic. The target flag sets one edge after the time reaches the target, so it is checked one cycle after the arming write or after the counting run ends.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
  localparam int unsigned NS_PER_SEC = 1000000000;
  localparam int TIME_W = 32;
  localparam int ADDR_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_ADDEND = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_UPDSEC = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_UPDNS  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_TGTSEC = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_TGTNS  = 3'd6;

  // control bit positions
  localparam int B_EN = 0;
  localparam int B_MASK = 1;
  localparam int B_INIT = 2;
  localparam int B_ADJ = 3;
  localparam int B_ADDEND = 4;
  localparam int B_ARM = 5;

  typedef struct packed {
    logic tsEnable;
    logic loadAddend;
    logic loadTime;
    logic addOffset;
  } timeStrobes_t;

  function automatic int unsigned stepFor(input int unsigned mhz);
    if (mhz > 200) return 10;
    else if (mhz > 100) return 20;
    else return 50;
  endfunction

  function automatic logic [31:0] nominalAddend(input int unsigned mhz, input int unsigned step);
    logic [63:0] num, den;
    den = 64'(mhz) * 64'd1000000 * 64'(step);
    num = (64'd1000000000 << 32) + (den >> 1);
    return 32'(num / den);
  endfunction
endpackage

// File: rtl/ptp_time_datapath.sv
module ptp_time_datapath
  import ptp_time_pkg::*;
#(
  parameter int unsigned STEP_NS = 20,
  parameter logic [31:0] ADDEND_RST = 32'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  timeStrobes_t      str,
  input  logic [31:0]       addendHold,
  input  logic [TIME_W-1:0] updSec,
  input  logic [31:0]       updNs,
  output logic [TIME_W-1:0] curSec,
  output logic [TIME_W-1:0] curNs
);
  localparam logic [31:0] NSMAX = 32'(NS_PER_SEC);
  localparam logic [31:0] STEP = 32'(STEP_NS);

  logic [31:0] activeAddend;
  logic [31:0] acc;
  logic [32:0] accSum;
  logic [31:0] tickNs, posNs, mag;
  logic [TIME_W-1:0] nextSec, nextNs;

  assign accSum = {1'b0, acc} + {1'b0, activeAddend};
  assign tickNs = curNs + STEP;
  assign mag = {1'b0, updNs[30:0]};
  assign posNs = curNs + mag;

  always_comb begin
    nextSec = curSec;
    nextNs = curNs;
    if (str.loadTime) begin
      nextSec = updSec;
      nextNs = updNs;
    end else if (str.addOffset) begin
      if (!updNs[31]) begin
        if (posNs >= NSMAX) begin
          nextNs = posNs - NSMAX;
          nextSec = curSec + updSec + 1'b1;
        end else begin
          nextNs = posNs;
          nextSec = curSec + updSec;
        end
      end else begin
        if (curNs >= mag) begin
          nextNs = curNs - mag;
          nextSec = curSec - updSec;
        end else begin
          nextNs = curNs + NSMAX - mag;
          nextSec = curSec - updSec - 1'b1;
        end
      end
    end else if (str.tsEnable && accSum[32]) begin
      if (tickNs >= NSMAX) begin
        nextNs = tickNs - NSMAX;
        nextSec = curSec + 1'b1;
      end else begin
        nextNs = tickNs;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeAddend <= ADDEND_RST;
      acc <= '0;
      curSec <= '0;
      curNs <= '0;
    end else begin
      if (str.loadAddend) activeAddend <= addendHold;
      if (str.tsEnable) acc <= accSum[31:0];
      curSec <= nextSec;
      curNs <= nextNs;
    end
  end

  assert_ns_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    curNs < NSMAX);
  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!str.tsEnable && !str.loadTime && !str.addOffset) |=> ($stable(curNs) && $stable(curSec)));
  assert_load_both_R4: assert property (@(posedge clk) disable iff (!rstN)
    str.loadTime |=> (curSec == $past(updSec) && curNs == $past(updNs)));
endmodule

// File: rtl/ptp_time_ctrl.sv
module ptp_time_ctrl
  import ptp_time_pkg::*;
#(
  parameter logic [31:0] ADDEND_RST = 32'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              statusRead,
  input  logic [TIME_W-1:0] curSec,
  input  logic [TIME_W-1:0] curNs,
  output timeStrobes_t      str,
  output logic [31:0]       addendHold,
  output logic [TIME_W-1:0] updSec,
  output logic [31:0]       updNs,
  output logic              targetArmed,
  output logic              targetFlag,
  output logic              irqOut
);
  logic tsEnable, irqMask;
  logic initPend, adjPend, addendPend;
  logic [TIME_W-1:0] tgtSec, tgtNs;
  logic ctrlWr, hit;

  assign ctrlWr = wrEn && (wrAddr == ADR_CTRL);
  assign hit = targetArmed && ({curSec, curNs} >= {tgtSec, tgtNs});

  assign str.tsEnable = tsEnable;
  assign str.loadAddend = addendPend;
  assign str.loadTime = initPend;
  assign str.addOffset = adjPend;
  assign irqOut = targetFlag && !irqMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsEnable <= 1'b0;
      irqMask <= 1'b0;
      initPend <= 1'b0;
      adjPend <= 1'b0;
      addendPend <= 1'b0;
      addendHold <= ADDEND_RST;
      updSec <= '0;
      updNs <= '0;
      tgtSec <= '0;
      tgtNs <= '0;
      targetArmed <= 1'b0;
      targetFlag <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          ADR_CTRL: begin
            tsEnable <= wrData[B_EN];
            irqMask <= wrData[B_MASK];
          end
          ADR_ADDEND: addendHold <= wrData;
          ADR_UPDSEC: updSec <= wrData;
          ADR_UPDNS: updNs <= wrData;
          ADR_TGTSEC: tgtSec <= wrData;
          ADR_TGTNS: tgtNs <= wrData;
          default: ;
        endcase
      end
      // time load and offset share one busy window
      if (initPend) initPend <= 1'b0;
      else if (ctrlWr && wrData[B_INIT] && !adjPend) initPend <= 1'b1;
      if (adjPend) adjPend <= 1'b0;
      else if (ctrlWr && wrData[B_ADJ] && !wrData[B_INIT] && !initPend) adjPend <= 1'b1;
      if (addendPend) addendPend <= 1'b0;
      else if (ctrlWr && wrData[B_ADDEND]) addendPend <= 1'b1;
      if (hit) targetArmed <= 1'b0;
      else if (ctrlWr && wrData[B_ARM]) targetArmed <= 1'b1;
      if (hit) targetFlag <= 1'b1;
      else if (statusRead) targetFlag <= 1'b0;
    end
  end

  assert_addend_selfclear_R3: assert property (@(posedge clk) disable iff (!rstN)
    addendPend |=> !addendPend);
  assert_one_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(initPend && adjPend));
  assert_flag_needs_arm_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(targetFlag) |-> ($past(targetArmed) && !targetArmed));
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqMask |-> !irqOut);
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_time_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 125
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              statusRead,
  output logic [TIME_W-1:0] timeSec,
  output logic [TIME_W-1:0] timeNs,
  output logic              addendBusy,
  output logic              initBusy,
  output logic              adjustBusy,
  output logic              targetArmed,
  output logic              targetFlag,
  output logic              irq
);
  localparam int unsigned STEP_NS = stepFor(CLK_MHZ);
  localparam logic [31:0] ADDEND_NOM = nominalAddend(CLK_MHZ, STEP_NS);

  timeStrobes_t str;
  logic [31:0] addendHold, updNs;
  logic [TIME_W-1:0] updSec;

  ptp_time_ctrl #(.ADDEND_RST(ADDEND_NOM)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusRead(statusRead), .curSec(timeSec), .curNs(timeNs), .str(str),
    .addendHold(addendHold), .updSec(updSec), .updNs(updNs),
    .targetArmed(targetArmed), .targetFlag(targetFlag), .irqOut(irq)
  );

  ptp_time_datapath #(.STEP_NS(STEP_NS), .ADDEND_RST(ADDEND_NOM)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .addendHold(addendHold),
    .updSec(updSec), .updNs(updNs), .curSec(timeSec), .curNs(timeNs)
  );

  assign addendBusy = str.loadAddend;
  assign initBusy = str.loadTime;
  assign adjustBusy = str.addOffset;
endmodule

// File: tb/ptp_time_counter_bench.sv
`timescale 1ns/1ps
module ptp_time_counter_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic statusRead = 1'b0;
  logic [31:0] timeSec, timeNs;
  logic addendBusy, initBusy, adjustBusy, targetArmed, targetFlag, irq;

  int total = 0;
  int bad = 0;
  logic [31:0] accM = 32'd0;
  logic [31:0] addM = 32'd1717986918;
  logic [31:0] eSec = 32'd0;
  logic [31:0] eNs = 32'd0;
  logic maskV = 1'b0;
  localparam longint unsigned STEP = 20;
  localparam longint unsigned BIL = 1000000000;

  always #4 clk = ~clk;

  ptp_time_counter u_ptp_time_counter (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusRead(statusRead), .timeSec(timeSec), .timeNs(timeNs),
    .addendBusy(addendBusy), .initBusy(initBusy), .adjustBusy(adjustBusy),
    .targetArmed(targetArmed), .targetFlag(targetFlag), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkTime(input string tag);
    chk(timeSec == eSec, {tag, " sec"}, longint'(timeSec), longint'(eSec));
    chk(timeNs == eNs, {tag, " ns"}, longint'(timeNs), longint'(eNs));
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [31:0] ctl(input logic en, input int setBit);
    logic [31:0] w;
    w = 32'd0;
    w[0] = en;
    w[1] = maskV;
    if (setBit >= 2) w[setBit] = 1'b1;
    return w;
  endfunction

  // M enabled cycles, expected time worked out arithmetically
  task automatic runTicks(input int m, input string tag);
    logic [63:0] sum, carries, ns64;
    wr(3'd0, ctl(1'b1, -1));
    idle(m - 1);
    wr(3'd0, ctl(1'b0, -1));
    sum = 64'(accM) + 64'(m) * 64'(addM);
    carries = sum >> 32;
    accM = sum[31:0];
    ns64 = 64'(eNs) + carries * STEP;
    eSec = eSec + 32'(ns64 / BIL);
    eNs = 32'(ns64 % BIL);
    chkTime(tag);
  endtask

  task automatic setAddend(input logic [31:0] a);
    wr(3'd1, a);
    wr(3'd0, ctl(1'b0, 4));
    chk(addendBusy == 1'b1, "R3 addend busy high", longint'(addendBusy), 1);
    idle(1);
    chk(addendBusy == 1'b0, "R3 addend busy clears", longint'(addendBusy), 0);
    addM = a;
  endtask

  task automatic loadTime(input logic [31:0] s, input logic [31:0] n);
    wr(3'd3, s);
    wr(3'd4, n);
    wr(3'd0, ctl(1'b0, 2));
    chk(initBusy == 1'b1, "R4 init busy high", longint'(initBusy), 1);
    idle(1);
    chk(initBusy == 1'b0, "R4 init busy clears", longint'(initBusy), 0);
    eSec = s; eNs = n;
    chkTime("R4 load");
  endtask

  task automatic adjust(input logic neg, input logic [31:0] s, input logic [30:0] n,
                        input logic [31:0] xs, input logic [31:0] xn, input string tag);
    wr(3'd3, s);
    wr(3'd4, {neg, n});
    wr(3'd0, ctl(1'b0, 3));
    chk(adjustBusy == 1'b1, "R6 adjust busy high", longint'(adjustBusy), 1);
    idle(1);
    eSec = xs; eNs = xn;
    chkTime(tag);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] adds [4];
    int ms [5];
    adds = '{32'h8000_0000, 32'h4000_0000, 32'hFFFF_FFFF, 32'd1717986918};
    ms = '{1, 2, 3, 7, 50};
    idle(3);
    rstN = 1'b1;
    // R10 reset state
    chk(timeSec == 0 && timeNs == 0, "R10 time zero", longint'(timeNs), 0);
    chk({addendBusy, initBusy, adjustBusy} == 3'b000, "R10 busy zero",
        longint'({addendBusy, initBusy, adjustBusy}), 0);
    chk({targetArmed, targetFlag, irq} == 3'b000, "R10 target zero",
        longint'({targetArmed, targetFlag, irq}), 0);

    // R1 R3 nominal addend straight out of reset
    runTicks(40, "R3 nominal addend rate");
    runTicks(7, "R1 nominal addend short");

    // R1 R2 sweep of addends and run lengths near a wrap
    loadTime(32'd5, 32'd999_999_900);
    foreach (adds[i]) begin
      setAddend(adds[i]);
      foreach (ms[j]) runTicks(ms[j], "R1 R2 sweep");
    end

    // R2 seconds wrap modulo 2^32
    setAddend(32'hFFFF_FFFF);
    loadTime(32'hFFFF_FFFF, 32'd999_999_990);
    runTicks(3, "R2 seconds wrap");

    // R7 disabled counter holds
    idle(6);
    chkTime("R7 hold while disabled");

    // R5 offset request ignored while a load is pending
    wr(3'd3, 32'd20);
    wr(3'd4, 32'd400);
    wr(3'd0, ctl(1'b0, 2));
    wr(3'd0, ctl(1'b0, 3));
    chk(adjustBusy == 1'b0, "R5 offset refused", longint'(adjustBusy), 0);
    eSec = 32'd20; eNs = 32'd400;
    chkTime("R5 load kept");
    idle(1);
    chkTime("R5 no late offset");

    // R6 offsets
    loadTime(32'd10, 32'd999_999_950);
    adjust(1'b0, 32'd1, 31'd100, 32'd12, 32'd50, "R6 add with carry");
    loadTime(32'd10, 32'd500);
    adjust(1'b1, 32'd2, 31'd600, 32'd7, 32'd999_999_900, "R6 subtract with borrow");
    loadTime(32'd10, 32'd800);
    adjust(1'b1, 32'd0, 31'd300, 32'd10, 32'd500, "R6 subtract no borrow");
    loadTime(32'd0, 32'd0);
    adjust(1'b1, 32'd0, 31'd1, 32'hFFFF_FFFF, 32'd999_999_999, "R6 subtract below zero");

    // R8 R9 target exactly equal
    loadTime(32'd3, 32'd1000);
    wr(3'd5, 32'd3);
    wr(3'd6, 32'd1000);
    wr(3'd0, ctl(1'b0, 5));
    idle(1);
    chk(targetFlag == 1'b1, "R8 equal target hits", longint'(targetFlag), 1);
    chk(targetArmed == 1'b0, "R8 one shot disarm", longint'(targetArmed), 0);
    chk(irq == 1'b1, "R9 irq unmasked", longint'(irq), 1);
    statusRead = 1'b1;
    @(posedge clk); #1;
    statusRead = 1'b0;
    chk(targetFlag == 1'b0 && irq == 1'b0, "R9 read clears flag", longint'(targetFlag), 0);
    idle(2);
    chk(targetFlag == 1'b0, "R8 no refire", longint'(targetFlag), 0);

    // R8 one ns short does not fire, then counting reaches it
    wr(3'd6, 32'd1001);
    wr(3'd0, ctl(1'b0, 5));
    idle(2);
    chk(targetFlag == 1'b0, "R8 below target quiet", longint'(targetFlag), 0);
    chk(targetArmed == 1'b1, "R8 still armed", longint'(targetArmed), 1);
    setAddend(32'h8000_0000);
    runTicks(4, "R8 run to target");
    idle(1);
    chk(targetFlag == 1'b1, "R8 reached by counting", longint'(targetFlag), 1);
    chk(targetArmed == 1'b0, "R8 disarm after count", longint'(targetArmed), 0);
    statusRead = 1'b1;
    @(posedge clk); #1;
    statusRead = 1'b0;

    // R9 masked flag keeps irq low
    maskV = 1'b1;
    wr(3'd0, ctl(1'b0, -1));
    wr(3'd6, eNs);
    wr(3'd0, ctl(1'b0, 5));
    idle(1);
    chk(targetFlag == 1'b1, "R9 masked flag set", longint'(targetFlag), 1);
    chk(irq == 1'b0, "R9 masked irq low", longint'(irq), 0);
    maskV = 1'b0;
    wr(3'd0, ctl(1'b0, -1));
    chk(irq == 1'b1, "R9 unmask raises irq", longint'(irq), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule